// File: doc/BRIEF.md
# ECC Memory Wrapper with Read-Modify-Write

This block sits between a 32-bit request bus and a synchronous memory whose words are 39 bits wide. Every stored word carries 32 data bits and 7 protection bits (a 6-bit Hamming check plus an overall parity bit), which gives single-error correction and double-error detection. Full-word writes are encoded and stored directly. Reads decode the stored word. A single flipped bit is repaired before the data is returned. A double flip is reported instead.

Writes that enable fewer than four bytes are done as an internal sequence. The block reads the containing word, repairs it, merges the enabled new bytes into it, re-encodes the result and writes it back. The request side uses a valid/ready handshake with per-byte enables. Each request ends with exactly one response pulse, so a master can keep one access in flight. A parameter sets the number of wait states charged for check generation and checking. It must be at least 1, and the default is 1.

Top module: `ecc_rmw_mem`

## Requirements
- R1: While reset is held and right after it is released, `reqReady` is 1 and `respValid`, `memEn` and `memWe` are 0.
- R2: A write with `reqBe` = 4'hF issues no memory read. It stores the data in `memWdata[31:0]` and pulses `respValid` exactly W+1 cycles after the accepting edge, where W is the wait-state parameter.
- R3: A read pulses `respValid` exactly W+2 cycles after the accepting edge, with the stored data on `respRdata`. `reqBe` has no effect on a read.
- R4: If any one of the 39 stored bits has flipped, a read returns the original data with `respCorr` = 1 and `respDed` = 0.
- R5: If two stored bits have flipped, a read reports `respDed` = 1 and `respCorr` = 0.
- R6: A write with `reqBe` other than 4'hF replaces byte i (bits 8i+7..8i) only when `reqBe[i]` is 1 and keeps the other bytes. It acknowledges exactly 2W+2 cycles after the accepting edge.
- R7: In a sub-word write to a word with one flipped bit, the kept bytes are the corrected ones and the acknowledge carries `respCorr` = 1. Reading the word afterwards shows no error.
- R8: In a sub-word write to a word with two flipped bits, the acknowledge carries `respDed` = 1 and no memory write is issued. The word stays uncorrectable.
- R9: `reqReady` stays 0 from the accepting edge until the acknowledge cycle ends, and it is 1 again in the following cycle. No memory access is issued while `reqReady` is 1.
- R10: An all-zero memory word decodes as zero data with no error flag.
- R11: `respCorr` and `respDed` are never 1 together, and neither is 1 outside a `respValid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge when valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqBe | input | 4 | Byte enables for writes |
| reqWdata | input | 32 | Write data |
| respValid | output | 1 | One-cycle response or acknowledge |
| respRdata | output | 32 | Corrected read data |
| respCorr | output | 1 | A single-bit error was corrected |
| respDed | output | 1 | An uncorrectable double error was found |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | 39 | Encoded word to store |
| memRdata | input | 39 | Stored word, valid the cycle after a read strobe |

## Verification
Correction and merging can meet in one operation: a sub-word write whose target word already holds a flipped bit. The bench injects one-bit and two-bit faults into its memory model between accesses. It then issues partial writes whose flipped bit lies either in a kept byte or in a replaced byte. Each outcome is judged by the flags on the acknowledge, the data field of the stored word, and a later read that must come back clean with the merged value. For a double-error word, the count of memory writes must not change.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DATA_W = 32;
  localparam int HAM_W  = 6;
  localparam int WORD_W = DATA_W + HAM_W + 1;
  localparam int BYTES  = DATA_W / 8;

  typedef struct packed {
    logic latchReq;
    logic capRd;
    logic loadMerge;
    logic memEn;
    logic memWe;
    logic respValid;
    logic showFlags;
  } ctlStrobes_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic corr;
    logic ded;
  } eccDec_t;

  // Hamming check over data bits placed at the non-power-of-two positions 3,5,6,7,9...
  function automatic logic [HAM_W-1:0] hamCheck(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    int p;
    c = '0;
    p = 2;
    for (int i = 0; i < DATA_W; i++) begin
      p++;
      if ((p & (p - 1)) == 0) p++;
      for (int j = 0; j < HAM_W; j++)
        if (p[j]) c[j] = c[j] ^ d[i];
    end
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    c = hamCheck(d);
    return {^{c, d}, c, d};
  endfunction

  function automatic eccDec_t eccDecode(input logic [WORD_W-1:0] w);
    eccDec_t r;
    logic [HAM_W-1:0] syn;
    logic par;
    int p;
    r.data = w[DATA_W-1:0];
    syn = hamCheck(w[DATA_W-1:0]) ^ w[DATA_W+HAM_W-1:DATA_W];
    par = ^w;
    r.corr = par;
    r.ded = !par && (syn != '0);
    p = 2;
    for (int i = 0; i < DATA_W; i++) begin
      p++;
      if ((p & (p - 1)) == 0) p++;
      if (par && (HAM_W'(p) == syn)) r.data[i] = ~w[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_rmw_dp.sv
module ecc_rmw_dp
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           ctl,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [BYTES-1:0]      reqBe,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [WORD_W-1:0]     memRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [WORD_W-1:0]     memWdata,
  output logic [DATA_W-1:0]     respRdata,
  output logic                  respCorr,
  output logic                  respDed,
  output logic                  dedNow
);
  logic [ADDR_W-1:0] addrQ;
  logic [BYTES-1:0]  beQ;
  logic [DATA_W-1:0] newQ;
  logic [DATA_W-1:0] wordQ;
  logic [WORD_W-1:0] codeQ;
  logic [WORD_W-1:0] codeSrc;
  logic [DATA_W-1:0] mergeData;
  eccDec_t           dec;

  // The first checking cycle decodes straight from the memory output.
  assign codeSrc = ctl.capRd ? memRdata : codeQ;
  assign dec     = eccDecode(codeSrc);

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign mergeData[8*b +: 8] = beQ[b] ? newQ[8*b +: 8] : dec.data[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      beQ   <= '0;
      newQ  <= '0;
      wordQ <= '0;
      codeQ <= '0;
    end else begin
      if (ctl.latchReq) begin
        addrQ <= reqAddr;
        beQ   <= reqBe;
        newQ  <= reqWdata;
        wordQ <= reqWdata;
      end
      if (ctl.capRd)     codeQ <= memRdata;
      if (ctl.loadMerge) wordQ <= mergeData;
    end
  end

  assign memAddr   = addrQ;
  assign memWdata  = eccEncode(wordQ);
  assign respRdata = dec.data;
  assign respCorr  = ctl.showFlags && dec.corr;
  assign respDed   = ctl.showFlags && dec.ded;
  assign dedNow    = dec.ded;
endmodule

// File: rtl/ecc_rmw_ctl.sv
module ecc_rmw_ctl
  import ecc_rmw_pkg::*;
#(
  parameter int WAIT_STATES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [BYTES-1:0] reqBe,
  input  logic             dedNow,
  output logic             reqReady,
  output ctlStrobes_t      ctl
);
  localparam int CNT_W = (WAIT_STATES < 2) ? 1 : $clog2(WAIT_STATES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RDWAIT, S_WRWAIT, S_WR, S_RESP} state_t;

  state_t state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic isWr, isRmw;
  logic lastWait;

  assign lastWait = (cnt == CNT_W'(WAIT_STATES - 1));

  always_comb begin
    stateNext = state;
    ctl       = '0;
    reqReady  = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          stateNext = (reqWrite && (reqBe == '1)) ? S_WRWAIT : S_RD;
        end
      end
      S_RD: begin
        ctl.memEn = 1'b1;
        stateNext = S_RDWAIT;
      end
      S_RDWAIT: begin
        ctl.capRd = (cnt == '0);
        if (lastWait) begin
          if (!isWr || dedNow) stateNext = S_RESP;
          else begin
            ctl.loadMerge = 1'b1;
            stateNext = S_WRWAIT;
          end
        end
      end
      S_WRWAIT: if (lastWait) stateNext = S_WR;
      S_WR: begin
        ctl.memEn     = 1'b1;
        ctl.memWe     = 1'b1;
        ctl.respValid = 1'b1;
        ctl.showFlags = isRmw;
        stateNext     = S_IDLE;
      end
      S_RESP: begin
        ctl.respValid = 1'b1;
        ctl.showFlags = 1'b1;
        stateNext     = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
      isRmw <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= (stateNext != state) ? '0 : cnt + 1'b1;
      if (ctl.latchReq) begin
        isWr  <= reqWrite;
        isRmw <= reqWrite && (reqBe != '1);
      end
    end
  end
endmodule

// File: rtl/ecc_rmw_mem.sv
module ecc_rmw_mem
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int WAIT_STATES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqBe,
  input  logic [31:0]       reqWdata,
  output logic              respValid,
  output logic [31:0]       respRdata,
  output logic              respCorr,
  output logic              respDed,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [38:0]       memWdata,
  input  logic [38:0]       memRdata
);
  ctlStrobes_t ctl;
  logic dedNow;

  ecc_rmw_ctl #(.WAIT_STATES(WAIT_STATES)) ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBe(reqBe), .dedNow(dedNow), .reqReady(reqReady), .ctl(ctl)
  );

  ecc_rmw_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqBe(reqBe),
    .reqWdata(reqWdata), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .respRdata(respRdata), .respCorr(respCorr),
    .respDed(respDed), .dedNow(dedNow)
  );

  assign memEn     = ctl.memEn;
  assign memWe     = ctl.memWe;
  assign respValid = ctl.respValid;
endmodule

// File: rtl/ecc_rmw_chk.sv
module ecc_rmw_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       reqWrite,
  input logic [3:0] reqBe,
  input logic       respValid,
  input logic       respCorr,
  input logic       respDed,
  input logic       memEn,
  input logic       memWe
);
  p_idle_no_access_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memEn);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_write_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn);

  p_full_write_no_early_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && reqBe == 4'hF) |=> !memEn);

  p_read_issues_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> (memEn && !memWe));

  p_ded_no_writeback_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respDed) |-> !memWe);

  p_ded_returns_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respDed) |=> reqReady);

  p_flags_qualified_r11: assert property (@(posedge clk) disable iff (!rstN)
    (respCorr || respDed) |-> respValid);

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(respCorr && respDed));
endmodule

bind ecc_rmw_mem ecc_rmw_chk chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .reqBe(reqBe), .respValid(respValid),
  .respCorr(respCorr), .respDed(respDed), .memEn(memEn), .memWe(memWe)
);

// File: tb/ecc_rmw_mem_tb_top.sv
module ecc_rmw_mem_tb_top;
  localparam int AW = 10;
  localparam int W  = 1;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [3:0] reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady, respValid, respCorr, respDed, memEn, memWe;
  logic [31:0] respRdata;
  logic [AW-1:0] memAddr;
  logic [38:0] memWdata;
  logic [38:0] memRdata;

  logic injGo = 1'b0;
  logic [AW-1:0] injAddr = '0;
  logic [38:0] injMask = '0;
  logic [38:0] mem [NW];
  int wrCount;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecc_rmw_mem #(.ADDR_W(AW), .WAIT_STATES(W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .respValid(respValid), .respRdata(respRdata), .respCorr(respCorr),
    .respDed(respDed), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // Synchronous memory model with fault injection port
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
      memRdata <= '0;
      wrCount  <= 0;
    end else begin
      if (injGo) mem[injAddr] <= mem[injAddr] ^ injMask;
      if (memEn) begin
        if (memWe) begin
          mem[memAddr] <= memWdata;
          wrCount <= wrCount + 1;
        end else memRdata <= mem[memAddr];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mergeRef(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
    return r;
  endfunction

  task automatic doOp(input bit wr, input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d,
                      output int lat, output logic [31:0] rd, output bit c, output bit e, output bit busyOk);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqBe = be; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    busyOk = 1;
    while (!respValid && lat < 50) begin
      if (reqReady) busyOk = 0;
      @(negedge clk);
      lat++;
    end
    if (reqReady) busyOk = 0;
    rd = respRdata; c = respCorr; e = respDed;
    @(negedge clk);
    if (!reqReady) busyOk = 0;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [38:0] m);
    @(negedge clk);
    injAddr = a; injMask = m; injGo = 1'b1;
    @(negedge clk);
    injGo = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin : main
    int lat; logic [31:0] rd; bit c, e, bo;
    logic [31:0] refData [16];
    int errState [16];
    int wc0;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    check(reqReady && !respValid && !memEn && !memWe, "R1 reset", {reqReady, respValid, memEn, memWe}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !respValid && !memEn && !memWe, "R1 after reset", {reqReady, respValid, memEn, memWe}, 4'b1000);

    // Zero word read, byte enables irrelevant
    doOp(0, 3, 4'h0, 0, lat, rd, c, e, bo);
    check(rd == 0 && !c && !e, "R10 zero word", {rd, c, e}, 0);
    check(lat == W + 2, "R3 read latency", lat, W + 2);
    check(bo, "R9 ready low during read", bo, 1);

    // Full write
    wc0 = wrCount;
    doOp(1, 1, 4'hF, 32'hDEADBEEF, lat, rd, c, e, bo);
    check(lat == W + 1, "R2 write latency", lat, W + 1);
    check(mem[1][31:0] == 32'hDEADBEEF, "R2 stored data", mem[1][31:0], 32'hDEADBEEF);
    check(wrCount == wc0 + 1 && bo, "R9 one write, ready low", wrCount - wc0, 1);
    doOp(0, 1, 4'h5, 0, lat, rd, c, e, bo);
    check(rd == 32'hDEADBEEF && !c && !e, "R3 read back", rd, 32'hDEADBEEF);

    // Sub-word merge
    doOp(1, 1, 4'h5, 32'h11223344, lat, rd, c, e, bo);
    check(lat == 2 * W + 2, "R6 rmw latency", lat, 2 * W + 2);
    check(bo, "R9 ready low during rmw", bo, 1);
    doOp(0, 1, 4'hF, 0, lat, rd, c, e, bo);
    check(rd == 32'hDE22BE44 && !c && !e, "R6 merged word", rd, 32'hDE22BE44);

    // Correction inside a merge: flip in kept byte
    inject(1, 39'd1 << 13);
    doOp(1, 1, 4'h1, 32'h000000AA, lat, rd, c, e, bo);
    check(c && !e, "R7 rmw corr flag", {c, e}, 2'b10);
    check(mem[1][31:0] == 32'hDE22BEAA, "R7 stored merged", mem[1][31:0], 32'hDE22BEAA);
    doOp(0, 1, 4'hF, 0, lat, rd, c, e, bo);
    check(rd == 32'hDE22BEAA && !c && !e, "R7 clean after rmw", {rd, c, e}, {32'hDE22BEAA, 2'b00});
    // Flip in replaced byte
    inject(1, 39'd1 << 2);
    doOp(1, 1, 4'h1, 32'h00000055, lat, rd, c, e, bo);
    check(c && !e, "R7 rmw corr in replaced byte", {c, e}, 2'b10);
    doOp(0, 1, 4'hF, 0, lat, rd, c, e, bo);
    check(rd == 32'hDE22BE55 && !c && !e, "R7 clean after replace", {rd, c, e}, {32'hDE22BE55, 2'b00});

    // Double error
    doOp(1, 2, 4'hF, 32'h12345678, lat, rd, c, e, bo);
    inject(2, (39'd1 << 4) | (39'd1 << 36));
    doOp(0, 2, 4'hF, 0, lat, rd, c, e, bo);
    check(e && !c, "R5 double detect", {c, e}, 2'b01);
    wc0 = wrCount;
    doOp(1, 2, 4'h3, 32'hFFFFFFFF, lat, rd, c, e, bo);
    check(e && !c, "R8 rmw ded ack", {c, e}, 2'b01);
    check(wrCount == wc0, "R8 no write", wrCount - wc0, 0);
    check(bo, "R8 ready returns", bo, 1);
    doOp(0, 2, 4'hF, 0, lat, rd, c, e, bo);
    check(e && !c, "R8 still uncorrectable", {c, e}, 2'b01);

    // Every single bit position
    for (int k = 0; k < 39; k++) begin
      logic [31:0] pat;
      pat = $urandom;
      doOp(1, 4, 4'hF, pat, lat, rd, c, e, bo);
      inject(4, 39'd1 << k);
      doOp(0, 4, 4'hF, 0, lat, rd, c, e, bo);
      check(rd == pat && c && !e, "R4 single bit correct", {rd, c, e}, {pat, 2'b10});
    end

    // Constrained random mix
    for (int i = 0; i < 16; i++) begin
      doOp(1, AW'(i), 4'hF, 0, lat, rd, c, e, bo);
      refData[i] = 0; errState[i] = 0;
    end
    for (int n = 0; n < 500; n++) begin
      int a, op;
      logic [31:0] d; logic [3:0] be;
      a = $urandom_range(15);
      op = $urandom_range(4);
      d = $urandom;
      be = 4'($urandom);
      if (op == 0) begin
        doOp(0, AW'(a), be, 0, lat, rd, c, e, bo);
        if (errState[a] == 2) check(e && !c, "R5 random ded", {c, e}, 2'b01);
        else check(rd == refData[a] && c == (errState[a] == 1) && !e && lat == W + 2,
                   "R4 random read", {rd, c, e}, {refData[a], errState[a] == 1, 1'b0});
        check(!(c && e), "R11 exclusive flags", {c, e}, 0);
      end else if (op == 1) begin
        doOp(1, AW'(a), 4'hF, d, lat, rd, c, e, bo);
        check(!c && !e && lat == W + 1 && mem[a][31:0] == d, "R2 random write", mem[a][31:0], d);
        refData[a] = d; errState[a] = 0;
      end else if (op == 2 && be != 4'hF) begin
        wc0 = wrCount;
        doOp(1, AW'(a), be, d, lat, rd, c, e, bo);
        if (errState[a] == 2)
          check(e && !c && wrCount == wc0, "R8 random ded rmw", {c, e, wrCount - wc0}, 2'b01);
        else begin
          refData[a] = mergeRef(refData[a], d, be);
          check(c == (errState[a] == 1) && !e && mem[a][31:0] == refData[a] && lat == 2 * W + 2,
                "R6 random rmw", mem[a][31:0], refData[a]);
          errState[a] = 0;
        end
        check(bo, "R9 random ready", bo, 1);
      end else if (errState[a] == 0) begin
        int b1, b2;
        b1 = $urandom_range(38);
        b2 = (b1 + 1 + $urandom_range(37)) % 39;
        if (op == 3) begin
          inject(AW'(a), 39'd1 << b1);
          errState[a] = 1;
        end else begin
          inject(AW'(a), (39'd1 << b1) | (39'd1 << b2));
          errState[a] = 2;
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule